// File: doc/BRIEF.md
# Processor exception entry controller

This block performs the architectural side of taking a synchronous exception in a small 32-bit core. A requester presents the faulting program counter, a cause code and, when relevant, a faulting virtual address. On one clock edge the block saves the PC, records the cause and the optional address, sets the exception-mode bit of the status word, and emits a one-cycle vector-valid pulse with a 2-bit code that selects the kernel, user or double-exception vector.

The vector depends on whether the core was already handling an exception. If exception mode was already set, the entry is a double exception and the PC goes to a dedicated double-exception PC register when one is configured, or to the level-1 saved-PC register when it is not. A second request input reports misaligned memory accesses. Depending on two configuration parameters, these become an alignment exception that carries the access address, or they are dropped. A status-word write port presets the mode bits, and a read port exposes the saved registers.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Synchronous reset clears the status word, level-1 saved PC, double-exception PC, cause and fault-address registers to zero, and holds vec_valid low.
- R2: With status bit 4 (exception mode) clear, an exception saves the PC in the level-1 saved-PC register. It yields vec_code 1 (user) when status bit 5 is set and vec_code 0 (kernel) when bit 5 is clear.
- R3: With status bit 4 set, an exception yields vec_code 2 (double). The PC goes to the double-exception PC register and the level-1 saved PC is left unchanged when HAS_DEPC is 1. When HAS_DEPC is 0, the PC goes to the level-1 saved-PC register and the double-exception PC reads as zero.
- R4: Every exception writes its cause code to the cause register and sets status bit 4, leaving every other status bit unchanged.
- R5: A raise with raise_has_addr high writes raise_addr to the fault-address register. A raise with raise_has_addr low leaves that register unchanged.
- R6: A misaligned access raises cause ALIGN_CAUSE (default 9) with misalign_pc as the PC and misalign_addr as the fault address, but only when UNALIGN_EXC is 1 and HW_ALIGN is 0. Otherwise it changes no register and produces no pulse.
- R7: vec_valid is high for exactly the one cycle after each edge that accepts an exception, and the register updates are visible in that same cycle.
- R8: When raise_valid and misalign_valid arrive together, the raise is taken and the misaligned access is dropped. When an exception and a status write arrive together, the exception wins and the write is discarded.
- R9: The read port returns, for rd_sel values 0 to 4 in turn: the status word, the level-1 saved PC, the double-exception PC, the cause zero-extended, and the fault address. Any other rd_sel value returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| raise_valid | input | 1 | Exception request |
| raise_pc | input | 32 | Faulting PC of the request |
| raise_cause | input | CAUSE_W | Cause code of the request |
| raise_has_addr | input | 1 | Request carries a faulting address |
| raise_addr | input | 32 | Faulting virtual address |
| misalign_valid | input | 1 | Misaligned access report |
| misalign_pc | input | 32 | PC of the misaligned access |
| misalign_addr | input | 32 | Address of the misaligned access |
| ps_wr_en | input | 1 | Status word write strobe |
| ps_wr_data | input | 32 | Status word write value |
| rd_sel | input | 3 | Register read select |
| rd_data | output | 32 | Selected register value |
| vec_valid | output | 1 | One-cycle vector pulse |
| vec_code | output | 2 | 0 kernel, 1 user, 2 double |

## Verification
The main function is driven with status words that cover every combination of the exception-mode and user-mode bits, including words with unrelated bits set. This separates the kernel, user and double vectors and shows that the mode bits are only ever OR-ed in. Two instances with different configurations receive the same requests. This separates routing to the double-exception PC register from the fallback to the level-1 register, and separates a misaligned access that raises an exception from one that is dropped. Requests with and without an address, simultaneous requests and a status write that collides with an exception show which register each source may touch.

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl #(
  parameter int              W           = 32,
  parameter int              CAUSE_W     = 6,
  parameter bit              HAS_DEPC    = 1'b1,
  parameter bit              UNALIGN_EXC = 1'b1,
  parameter bit              HW_ALIGN    = 1'b0,
  parameter logic [CAUSE_W-1:0] ALIGN_CAUSE = 9,
  parameter int              EXCM_BIT    = 4,
  parameter int              UM_BIT      = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               raise_valid,
  input  logic [W-1:0]       raise_pc,
  input  logic [CAUSE_W-1:0] raise_cause,
  input  logic               raise_has_addr,
  input  logic [W-1:0]       raise_addr,
  input  logic               misalign_valid,
  input  logic [W-1:0]       misalign_pc,
  input  logic [W-1:0]       misalign_addr,
  input  logic               ps_wr_en,
  input  logic [W-1:0]       ps_wr_data,
  input  logic [2:0]         rd_sel,
  output logic [W-1:0]       rd_data,
  output logic               vec_valid,
  output logic [1:0]         vec_code
);

  localparam logic [1:0] V_KERNEL = 2'd0;
  localparam logic [1:0] V_USER   = 2'd1;
  localparam logic [1:0] V_DOUBLE = 2'd2;
  localparam bit MIS_EN = UNALIGN_EXC && !HW_ALIGN;

  logic [W-1:0]       ps_q, epc1_q, depc_q, va_q;
  logic [CAUSE_W-1:0] cause_q;

  logic               take_mis, take, dbl, has_va;
  logic [W-1:0]       pc_in, va_in;
  logic [CAUSE_W-1:0] cause_in;
  logic [1:0]         code_in;

  assign take_mis = misalign_valid && MIS_EN && !raise_valid;
  assign take     = raise_valid || take_mis;
  assign pc_in    = raise_valid ? raise_pc    : misalign_pc;
  assign va_in    = raise_valid ? raise_addr  : misalign_addr;
  assign cause_in = raise_valid ? raise_cause : ALIGN_CAUSE;
  assign has_va   = raise_valid ? raise_has_addr : 1'b1;
  assign dbl      = ps_q[EXCM_BIT];
  assign code_in  = dbl ? V_DOUBLE : (ps_q[UM_BIT] ? V_USER : V_KERNEL);

  always_ff @(posedge clk) begin
    if (rst) begin
      ps_q      <= '0;
      epc1_q    <= '0;
      depc_q    <= '0;
      va_q      <= '0;
      cause_q   <= '0;
      vec_valid <= 1'b0;
      vec_code  <= V_KERNEL;
    end else begin
      vec_valid <= take;
      if (take) begin
        vec_code          <= code_in;
        cause_q           <= cause_in;
        ps_q[EXCM_BIT]    <= 1'b1;
        if (has_va) va_q  <= va_in;
        if (dbl && HAS_DEPC) depc_q <= pc_in;
        else                 epc1_q <= pc_in;
      end else if (ps_wr_en) begin
        ps_q <= ps_wr_data;
      end
    end
  end

  always_comb begin
    case (rd_sel)
      3'd0:    rd_data = ps_q;
      3'd1:    rd_data = epc1_q;
      3'd2:    rd_data = HAS_DEPC ? depc_q : '0;
      3'd3:    rd_data = W'(cause_q);
      3'd4:    rd_data = va_q;
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk #(
  parameter int                 W           = 32,
  parameter int                 CAUSE_W     = 6,
  parameter logic [CAUSE_W-1:0] ALIGN_CAUSE = 9,
  parameter bit                 MIS_EN      = 1'b1,
  parameter int                 EXCM_BIT    = 4,
  parameter int                 UM_BIT      = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               raise_valid,
  input logic [W-1:0]       raise_pc,
  input logic [CAUSE_W-1:0] raise_cause,
  input logic               misalign_valid,
  input logic [W-1:0]       misalign_pc,
  input logic               vec_valid,
  input logic [1:0]         vec_code,
  input logic [W-1:0]       ps,
  input logic [W-1:0]       epc1,
  input logic [CAUSE_W-1:0] cause
);

  p_excm_set_r4: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> ps[EXCM_BIT]);

  p_cause_r4: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> cause == ($past(raise_valid) ? $past(raise_cause) : ALIGN_CAUSE));

  p_double_r3: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && $past(ps[EXCM_BIT])) |-> vec_code == 2'd2);

  p_mode_r2: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && !$past(ps[EXCM_BIT])) |-> vec_code == ($past(ps[UM_BIT]) ? 2'd1 : 2'd0));

  p_epc_r2: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && !$past(ps[EXCM_BIT])) |->
      epc1 == ($past(raise_valid) ? $past(raise_pc) : $past(misalign_pc)));

  p_source_r7: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> $past(raise_valid || (MIS_EN && misalign_valid)));

  p_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (!MIS_EN && misalign_valid && !raise_valid) |=> !vec_valid);

endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(
  .W(W), .CAUSE_W(CAUSE_W), .ALIGN_CAUSE(ALIGN_CAUSE),
  .MIS_EN(UNALIGN_EXC && !HW_ALIGN), .EXCM_BIT(EXCM_BIT), .UM_BIT(UM_BIT)
) u_chk (
  .clk(clk), .rst(rst), .raise_valid(raise_valid), .raise_pc(raise_pc),
  .raise_cause(raise_cause), .misalign_valid(misalign_valid),
  .misalign_pc(misalign_pc), .vec_valid(vec_valid), .vec_code(vec_code),
  .ps(ps_q), .epc1(epc1_q), .cause(cause_q)
);

// File: tb/tb_exc_entry_ctrl.sv
module tb_exc_entry_ctrl;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst, raise_valid, raise_has_addr, misalign_valid, ps_wr_en;
  logic [31:0] raise_pc, raise_addr, misalign_pc, misalign_addr, ps_wr_data;
  logic [5:0]  raise_cause;
  logic [2:0]  rd_sel;
  logic [31:0] rd_a, rd_b;
  logic        vv_a, vv_b;
  logic [1:0]  vc_a, vc_b;

  exc_entry_ctrl dut (
    .clk(clk), .rst(rst), .raise_valid(raise_valid), .raise_pc(raise_pc),
    .raise_cause(raise_cause), .raise_has_addr(raise_has_addr), .raise_addr(raise_addr),
    .misalign_valid(misalign_valid), .misalign_pc(misalign_pc), .misalign_addr(misalign_addr),
    .ps_wr_en(ps_wr_en), .ps_wr_data(ps_wr_data), .rd_sel(rd_sel),
    .rd_data(rd_a), .vec_valid(vv_a), .vec_code(vc_a));

  exc_entry_ctrl #(.HAS_DEPC(1'b0), .HW_ALIGN(1'b1)) dut_b (
    .clk(clk), .rst(rst), .raise_valid(raise_valid), .raise_pc(raise_pc),
    .raise_cause(raise_cause), .raise_has_addr(raise_has_addr), .raise_addr(raise_addr),
    .misalign_valid(misalign_valid), .misalign_pc(misalign_pc), .misalign_addr(misalign_addr),
    .ps_wr_en(ps_wr_en), .ps_wr_data(ps_wr_data), .rd_sel(rd_sel),
    .rd_data(rd_b), .vec_valid(vv_b), .vec_code(vc_b));

  typedef struct packed {
    logic [31:0] ps;
    logic [31:0] pc;
    logic [5:0]  cause;
    logic        has_addr;
    logic [31:0] addr;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t TBL [NV] = '{
    '{32'h0000_0000, 32'h0000_1000, 6'd3,  1'b1, 32'hDEAD_0001},
    '{32'h0000_0020, 32'h0000_2004, 6'd7,  1'b0, 32'h1111_1111},
    '{32'h0000_0010, 32'h0000_3008, 6'd12, 1'b1, 32'hBEEF_0002},
    '{32'h0000_0030, 32'h0000_400C, 6'd20, 1'b0, 32'h2222_2222},
    '{32'h0000_00A5, 32'h8000_5010, 6'd1,  1'b1, 32'hCAFE_0003},
    '{32'h0000_000F, 32'h0000_6014, 6'd63, 1'b1, 32'h0000_0004},
    '{32'hFFFF_FFDF, 32'h0000_7018, 6'd5,  1'b0, 32'h3333_3333}
  };

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] a, output logic [31:0] b);
    rd_sel = s; #1; a = rd_a; b = rd_b;
  endtask

  task automatic idle();
    raise_valid = 0; misalign_valid = 0; ps_wr_en = 0; raise_has_addr = 0;
  endtask

  task automatic wr_ps(input logic [31:0] v);
    @(negedge clk); ps_wr_en = 1; ps_wr_data = v;
    @(negedge clk); ps_wr_en = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b, ea1, eb1, ead, eva_a, eva_b, ps_a, ps_b, exp_ps;
    logic [1:0]  ec;
    rst = 1; idle(); raise_pc = 0; raise_cause = 0; raise_addr = 0;
    misalign_pc = 0; misalign_addr = 0; ps_wr_data = 0; rd_sel = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int s = 0; s < 5; s++) begin
      rd(3'(s), a, b);
      chk("R1 reset reg", a, 0);
      chk("R1 reset reg b", b, 0);
    end
    chk("R1 vec_valid low", {31'd0, vv_a}, 0);
    rst = 0;

    ea1 = 0; eb1 = 0; ead = 0; eva_a = 0; eva_b = 0;
    for (int i = 0; i < NV; i++) begin
      wr_ps(TBL[i].ps);
      @(negedge clk);
      raise_valid = 1; raise_pc = TBL[i].pc; raise_cause = TBL[i].cause;
      raise_has_addr = TBL[i].has_addr; raise_addr = TBL[i].addr;
      @(negedge clk);
      idle();
      if (TBL[i].ps[4]) begin
        ec = 2; ead = TBL[i].pc; eb1 = TBL[i].pc;
      end else begin
        ec = TBL[i].ps[5] ? 2'd1 : 2'd0; ea1 = TBL[i].pc; eb1 = TBL[i].pc;
      end
      if (TBL[i].has_addr) begin eva_a = TBL[i].addr; eva_b = TBL[i].addr; end
      chk("R7 vec_valid pulse", {30'd0, vv_a, vv_b}, 32'd3);
      chk("R2 R3 vec_code", {28'd0, vc_a, vc_b}, {28'd0, ec, ec});
      rd(1, a, b);
      chk("R2 R3 epc1", a, ea1);
      chk("R3 epc1 no depc", b, eb1);
      rd(2, a, b);
      chk("R3 depc", a, ead);
      chk("R3 depc absent", b, 0);
      rd(3, a, b);
      chk("R4 cause", a, {26'd0, TBL[i].cause});
      rd(0, a, b);
      chk("R4 status", a, TBL[i].ps | 32'h10);
      rd(4, a, b);
      chk("R5 fault addr", a, eva_a);
      @(negedge clk);
      chk("R7 pulse ends", {31'd0, vv_a}, 0);
    end

    // R6: misaligned access, kernel mode
    wr_ps(32'h0);
    @(negedge clk);
    misalign_valid = 1; misalign_pc = 32'h0000_9000; misalign_addr = 32'h0000_0103;
    @(negedge clk);
    idle();
    chk("R6 misalign raises", {31'd0, vv_a}, 1);
    chk("R6 misalign dropped", {31'd0, vv_b}, 0);
    rd(3, a, b);
    chk("R6 align cause", a, 9);
    chk("R6 cause unchanged b", b, 5);
    rd(4, a, b);
    chk("R6 align addr", a, 32'h0000_0103);
    chk("R6 addr unchanged b", b, eva_b);
    rd(1, a, b);
    chk("R6 align pc", a, 32'h0000_9000);
    chk("R6 epc unchanged b", b, eb1);
    rd(0, a, b);
    chk("R6 status b unchanged", b, 0);

    // R8: raise and misalign together
    wr_ps(32'h0000_0020);
    @(negedge clk);
    raise_valid = 1; raise_pc = 32'h0000_A000; raise_cause = 6'd17; raise_has_addr = 0;
    misalign_valid = 1; misalign_pc = 32'h0000_B000; misalign_addr = 32'h0000_0007;
    @(negedge clk);
    idle();
    rd(3, a, b);
    chk("R8 raise beats misalign cause", a, 17);
    rd(1, a, b);
    chk("R8 raise beats misalign pc", a, 32'h0000_A000);
    rd(4, a, b);
    chk("R8 addr untouched", a, 32'h0000_0103);
    chk("R8 user code", {30'd0, vc_a}, 1);

    // R8: status write collides with exception
    wr_ps(32'h0000_0001);
    @(negedge clk);
    raise_valid = 1; raise_pc = 32'h0000_C000; raise_cause = 6'd2;
    ps_wr_en = 1; ps_wr_data = 32'h0000_0F20;
    @(negedge clk);
    idle();
    rd(0, a, b);
    chk("R8 status write discarded", a, 32'h0000_0011);

    // R9: unused selects
    rd(5, a, b); chk("R9 sel5 zero", a, 0);
    rd(7, a, b); chk("R9 sel7 zero", a, 0);

    // R1: reset mid-run
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    for (int s = 0; s < 5; s++) begin
      rd(3'(s), a, b);
      chk("R1 reset again", a, 0);
    end
    chk("R1 vec low after reset", {31'd0, vv_a}, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule